// File: doc/BRIEF.md
# Complete-Sequence Checksum Response Analyzer

This block judges the output stream of a chain of cells under test. The chain is expected to be bijective, so during one test configuration it should emit each k-bit value exactly once across 2^K valid samples. The arrival order does not matter. A fault breaks this property: some value turns up twice and another never appears. The analyzer detects this without a stored golden response.

A start strobe opens each configuration. The block adds every accepted sample into an accumulator 2K bits wide. After the 2^K-th sample it compares the total with 2^K·(2^K−1)/2. A build-time option adds a 2^K-bit occupancy map. With the map, any repeated value fails the configuration as soon as the repeat arrives, which makes the check exact. The block also fails a configuration whose sample count was wrong, and it reports this when the next start strobe arrives. Every verdict is a one-cycle pulse on the done output, with exactly one of pass or fail.

Top module: `cseq_analyzer`

## Requirements
- R1: After reset, resultDone, resultPass and resultFail are low. Valid samples that arrive before the first startCfg produce no verdict.
- R2: When a configuration's 2^K samples hold every K-bit value once, in any order, resultDone and resultPass go high in the cycle after the last sample, and resultFail stays low.
- R3: A verdict lasts one cycle. resultPass and resultFail are never high together, and neither is high without resultDone.
- R4: With the map disabled, a configuration fails if the sum of its 2^K samples differs from 2^K·(2^K−1)/2. The sum is held without wrap-around, so 2^K copies of the all-ones value fail.
- R5: With the map enabled, the first sample that repeats an earlier value of the same configuration raises done with fail in the next cycle. That configuration gives no further verdict when its count completes.
- R6: With the map disabled, a stream whose repeats keep the sum unchanged (for example, each of two values appearing twice while two others are absent) passes.
- R7: If startCfg arrives after fewer than 2^K samples and no verdict has yet been given for that configuration, done with fail is raised in the next cycle.
- R8: If valid samples arrive after the 2^K-th and before the next startCfg, that startCfg raises done with fail in the next cycle. A startCfg that follows a complete configuration with no extra samples raises no verdict.
- R9: A sample that is valid in the same cycle as startCfg counts as the first sample of the new configuration.
- R10: Cycles with sampleValid low do not count as samples and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startCfg | input | 1 | Opens a new configuration |
| sampleValid | input | 1 | sampleData carries a sample this cycle |
| sampleData | input | K | Output value of the chain under test |
| resultDone | output | 1 | One-cycle verdict pulse |
| resultPass | output | 1 | Verdict is pass (only with resultDone) |
| resultFail | output | 1 | Verdict is fail (only with resultDone) |

## Verification
The bench builds two copies at K=3, one with the occupancy map and one without, and drives both with the same stream. With eight samples per configuration, shuffled permutations, idle gaps, short and overlong counts, a start strobe that coincides with a sample, and a sum-preserving pair of repeats all fit in a short run. That last stream passes on the sum-only copy and fails early on the mapped copy, so the difference between the two modes is observed cycle by cycle.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // start of a configuration: drop accumulated state
    logic accept;  // take sampleData into count, sum and map
  } cseqStrobe_t;

  // datapath findings for the sample presented this cycle
  typedef struct packed {
    logic isLast;    // this sample completes the 2^K count
    logic dupHit;    // value already seen in this configuration
    logic sumMatch;  // sum including this sample equals the target
  } cseqStatus_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_TAIL    = 2'd2
  } cseqPhase_t;

endpackage

// File: rtl/cseq_datapath.sv
module cseq_datapath
  import cseq_pkg::*;
#(
  parameter int K          = 4,
  parameter bit USE_BITMAP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cseqStrobe_t      strb,
  input  logic [K-1:0]     sampleData,
  output cseqStatus_t      stat
);

  localparam int N  = 1 << K;
  localparam int CW = K + 1;
  localparam int AW = 2 * K;
  localparam logic [AW-1:0] EXP_SUM = AW'((N / 2) * (N - 1));

  logic [CW-1:0] sampleCnt;
  logic [AW-1:0] sumAcc;
  logic [CW-1:0] baseCnt;
  logic [AW-1:0] baseAcc;
  logic [AW-1:0] sumNext;
  logic          dupHit;

  always_comb begin
    baseCnt       = strb.clear ? '0 : sampleCnt;
    baseAcc       = strb.clear ? '0 : sumAcc;
    sumNext       = baseAcc + AW'(sampleData);
    stat.isLast   = (baseCnt == CW'(N - 1));
    stat.sumMatch = (sumNext == EXP_SUM);
    stat.dupHit   = dupHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      sumAcc    <= '0;
    end else if (strb.accept) begin
      sampleCnt <= baseCnt + CW'(1);
      sumAcc    <= sumNext;
    end else if (strb.clear) begin
      sampleCnt <= '0;
      sumAcc    <= '0;
    end
  end

  generate
    if (USE_BITMAP) begin : g_map
      logic [N-1:0] seenMap;
      logic [N-1:0] baseMap;

      assign baseMap = strb.clear ? '0 : seenMap;
      assign dupHit  = strb.accept && baseMap[sampleData];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          seenMap <= '0;
        end else if (strb.accept) begin
          seenMap <= baseMap | (N'(1) << sampleData);
        end else if (strb.clear) begin
          seenMap <= '0;
        end
      end
    end else begin : g_nomap
      assign dupHit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cseq_control.sv
module cseq_control
  import cseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startCfg,
  input  logic         sampleValid,
  input  cseqStatus_t  stat,
  output cseqStrobe_t  strb,
  output logic         resultDone,
  output logic         resultPass,
  output logic         resultFail
);

  cseqPhase_t phase, phaseNxt;
  logic given, givenNxt;      // verdict already issued for this configuration
  logic overrun, overrunNxt;  // samples arrived after the count completed
  logic vDone, vPass;

  always_comb begin
    strb.clear  = startCfg;
    strb.accept = sampleValid && (startCfg || phase == PH_COLLECT);

    vDone      = 1'b0;
    vPass      = 1'b0;
    phaseNxt   = phase;
    givenNxt   = given;
    overrunNxt = overrun;

    if (startCfg) begin
      vDone      = (phase == PH_COLLECT && !given) || (phase == PH_TAIL && overrun);
      phaseNxt   = PH_COLLECT;
      givenNxt   = 1'b0;
      overrunNxt = 1'b0;
    end else if (phase == PH_COLLECT && sampleValid) begin
      if (stat.isLast) begin
        vDone    = !given;
        vPass    = !given && stat.sumMatch && !stat.dupHit;
        phaseNxt = PH_TAIL;
      end else if (stat.dupHit && !given) begin
        vDone    = 1'b1;
        givenNxt = 1'b1;
      end
    end else if (phase == PH_TAIL && sampleValid) begin
      overrunNxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      given      <= 1'b0;
      overrun    <= 1'b0;
      resultDone <= 1'b0;
      resultPass <= 1'b0;
      resultFail <= 1'b0;
    end else begin
      phase      <= phaseNxt;
      given      <= givenNxt;
      overrun    <= overrunNxt;
      resultDone <= vDone;
      resultPass <= vPass;
      resultFail <= vDone && !vPass;
    end
  end

endmodule

// File: rtl/cseq_analyzer.sv
module cseq_analyzer
  import cseq_pkg::*;
#(
  parameter int K          = 4,
  parameter bit USE_BITMAP = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startCfg,
  input  logic         sampleValid,
  input  logic [K-1:0] sampleData,
  output logic         resultDone,
  output logic         resultPass,
  output logic         resultFail
);

  cseqStrobe_t ctrlStrb;
  cseqStatus_t dpStat;

  cseq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startCfg   (startCfg),
    .sampleValid(sampleValid),
    .stat       (dpStat),
    .strb       (ctrlStrb),
    .resultDone (resultDone),
    .resultPass (resultPass),
    .resultFail (resultFail)
  );

  cseq_datapath #(.K(K), .USE_BITMAP(USE_BITMAP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (ctrlStrb),
    .sampleData(sampleData),
    .stat      (dpStat)
  );

endmodule

// File: rtl/cseq_analyzer_chk.sv
module cseq_analyzer_chk #(
  parameter bit USE_BITMAP = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic startCfg,
  input logic sampleValid,
  input logic acceptStrb,
  input logic sumMatch,
  input logic dupHit,
  input logic resultDone,
  input logic resultPass,
  input logic resultFail
);

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resultPass && resultFail)); // R3

  AST_VERDICT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (resultPass || resultFail) == resultDone); // R3

  AST_PASS_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rstN)
    resultPass |-> $past(acceptStrb && sumMatch)); // R2

  AST_MAP_PASS_NO_DUP: assert property (@(posedge clk) disable iff (!rstN)
    (USE_BITMAP && resultPass) |-> !$past(dupHit)); // R5

  AST_START_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    startCfg |=> !resultPass); // R7

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    acceptStrb |-> sampleValid); // R10

endmodule

bind cseq_analyzer cseq_analyzer_chk #(.USE_BITMAP(USE_BITMAP)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startCfg   (startCfg),
  .sampleValid(sampleValid),
  .acceptStrb (ctrlStrb.accept),
  .sumMatch   (dpStat.sumMatch),
  .dupHit     (dpStat.dupHit),
  .resultDone (resultDone),
  .resultPass (resultPass),
  .resultFail (resultFail)
);

// File: tb/sim_cseq_analyzer.sv
module sim_cseq_analyzer;

  localparam int PERIOD = 10;
  localparam int K      = 3;
  localparam int N      = 1 << K;
  localparam int TARGET = N * (N - 1) / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCfg = 1'b0;
  logic sampleValid = 1'b0;
  logic [K-1:0] sampleData = '0;
  logic d0, p0, f0, d1, p1, f1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // model state: index 0 = map enabled, 1 = sum only
  int  cfgQ[$];
  int  phase = 0;  // 0 idle, 1 collecting, 2 tail
  bit  given[2];
  bit  overrun = 0;
  bit  expDone[2], expPass[2], expFail[2];
  int  vCnt[2];
  bit  vPass[2];

  always #(PERIOD / 2) clk = ~clk;

  cseq_analyzer #(.K(K), .USE_BITMAP(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .startCfg(startCfg), .sampleValid(sampleValid),
    .sampleData(sampleData), .resultDone(d0), .resultPass(p0), .resultFail(f0));

  cseq_analyzer #(.K(K), .USE_BITMAP(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .startCfg(startCfg), .sampleValid(sampleValid),
    .sampleData(sampleData), .resultDone(d1), .resultPass(p1), .resultFail(f1));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit inQ(input int v);
    foreach (cfgQ[i]) if (cfgQ[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int sumQ();
    int s = 0;
    foreach (cfgQ[i]) s += cfgQ[i];
    return s;
  endfunction

  task automatic model(input bit s, input bit v, input int d);
    bit dup[2];
    for (int m = 0; m < 2; m++) begin
      expDone[m] = 0; expPass[m] = 0; expFail[m] = 0;
    end
    if (s) begin
      for (int m = 0; m < 2; m++)
        if ((phase == 1 && !given[m]) || (phase == 2 && overrun)) begin
          expDone[m] = 1; expFail[m] = 1;
        end
      phase = 1; cfgQ.delete(); given[0] = 0; given[1] = 0; overrun = 0;
      if (v) cfgQ.push_back(d);
    end else if (phase == 1 && v) begin
      dup[0] = inQ(d);
      dup[1] = 0;
      cfgQ.push_back(d);
      if (cfgQ.size() == N) begin
        for (int m = 0; m < 2; m++)
          if (!given[m]) begin
            expDone[m] = 1;
            expPass[m] = (sumQ() == TARGET) && !dup[m];
            expFail[m] = !expPass[m];
          end
        phase = 2;
      end else begin
        for (int m = 0; m < 2; m++)
          if (dup[m] && !given[m]) begin
            expDone[m] = 1; expFail[m] = 1; given[m] = 1;
          end
      end
    end else if (phase == 2 && v) begin
      overrun = 1;
    end
  endtask

  // compare outputs with the model on each falling edge, then drive
  task automatic tick(input bit s, input bit v, input int d);
    @(negedge clk);
    check("R3 u0 done", d0, expDone[0]);
    check("R3 u0 pass", p0, expPass[0]);
    check("R3 u0 fail", f0, expFail[0]);
    check("R3 u1 done", d1, expDone[1]);
    check("R3 u1 pass", p1, expPass[1]);
    check("R3 u1 fail", f1, expFail[1]);
    if (d0) begin vCnt[0]++; vPass[0] = p0; end
    if (d1) begin vCnt[1]++; vPass[1] = p1; end
    startCfg = s; sampleValid = v; sampleData = K'(d);
    model(s, v, d);
  endtask

  task automatic clearVerdicts();
    vCnt[0] = 0; vCnt[1] = 0; vPass[0] = 0; vPass[1] = 0;
  endtask

  task automatic sendCfg(input int vals[N], input bit startWithFirst, input int gap);
    if (!startWithFirst) tick(1, 0, 0);
    for (int i = 0; i < N; i++) begin
      tick(startWithFirst && i == 0, 1, vals[i]);
      for (int g = 0; g < gap; g++) tick(0, 0, 0);
    end
    tick(0, 0, 0);
    tick(0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      given[m] = 0; expDone[m] = 0; expPass[m] = 0; expFail[m] = 0;
    end
    clearVerdicts();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and samples before any start
    @(negedge clk);
    check("R1 reset done", d0 | d1, 0);
    check("R1 reset pass/fail", p0 | f0 | p1 | f1, 0);
    for (int i = 0; i < 12; i++) tick(0, 1, i % 3);
    tick(0, 0, 0); tick(0, 0, 0);
    check("R1 no verdict before start", vCnt[0] + vCnt[1], 0);

    // R2: ascending permutation
    clearVerdicts();
    sendCfg('{0, 1, 2, 3, 4, 5, 6, 7}, 0, 0);
    check("R2 ascending u0 pass", vPass[0], 1);
    check("R2 ascending u1 pass", vPass[1], 1);
    check("R3 single verdict", vCnt[0] + vCnt[1], 2);

    // R10: shuffled with idle gaps
    clearVerdicts();
    sendCfg('{5, 2, 7, 0, 3, 6, 1, 4}, 0, 2);
    check("R10 gapped shuffle u0", vPass[0], 1);
    check("R10 gapped shuffle u1", vPass[1], 1);
    check("R8 clean start no extra verdict", vCnt[0] + vCnt[1], 2);

    // R4: missing value, different sum
    clearVerdicts();
    sendCfg('{0, 1, 2, 3, 4, 5, 6, 6}, 0, 0);
    check("R4 bad sum u1 verdicts", vCnt[1], 1);
    check("R4 bad sum u1 pass", vPass[1], 0);
    check("R5 late dup u0 pass", vPass[0], 0);

    // R4: all ones, no wrap
    clearVerdicts();
    sendCfg('{7, 7, 7, 7, 7, 7, 7, 7}, 0, 0);
    check("R4 all ones u1 pass", vPass[1], 0);
    check("R5 all ones u0 one verdict", vCnt[0], 1);

    // R5 / R6: sum-preserving repeats
    clearVerdicts();
    sendCfg('{0, 0, 3, 3, 4, 4, 7, 7}, 0, 1);
    check("R6 sum-only passes swap", vPass[1], 1);
    check("R5 map fails early", vPass[0], 0);
    check("R5 map one verdict", vCnt[0], 1);

    // R7: short configuration
    clearVerdicts();
    tick(1, 0, 0);
    tick(0, 1, 1); tick(0, 1, 2); tick(0, 1, 3);
    // R9: restart carries first sample
    tick(1, 1, 6);
    tick(0, 0, 0); tick(0, 0, 0);
    check("R7 short u0 fail", vCnt[0] == 1 && !vPass[0], 1);
    check("R7 short u1 fail", vCnt[1] == 1 && !vPass[1], 1);
    clearVerdicts();
    for (int i = 0; i < N; i++) if (i != 6) tick(0, 1, i);
    tick(0, 0, 0); tick(0, 0, 0);
    check("R9 start sample counted u0", vCnt[0] == 1 && vPass[0], 1);
    check("R9 start sample counted u1", vCnt[1] == 1 && vPass[1], 1);

    // R8: overlong configuration
    clearVerdicts();
    tick(0, 1, 2);
    tick(0, 0, 0);
    check("R8 extra sample silent", vCnt[0] + vCnt[1], 0);
    tick(1, 0, 0);
    tick(0, 0, 0); tick(0, 0, 0);
    check("R8 overrun u0 fail", vCnt[0] == 1 && !vPass[0], 1);
    check("R8 overrun u1 fail", vCnt[1] == 1 && !vPass[1], 1);

    tick(0, 0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule